// File: doc/BRIEF.md
# Converter Host Bus Interface

This block is the digital control and read-back side of a 12-bit successive-approximation converter, as a microprocessor bus sees it. A request is qualified by an active-high enable together with an active-low select. The read/convert line then chooses between starting a conversion and driving the result onto a tri-stated data bus. The analog comparator is replaced by a digital sample word. The approximation register compares a trial code against that word, one bit per clock, from the MSB down.

The half-select line has two jobs, chosen by the cycle type. When a conversion starts, it picks a full 12-bit conversion or one cut short to 8 bits. During a read, with the width-mode line low, it picks which part of the result is driven. This lets the result reach an 8-bit bus in two reads. With the width-mode line high, all 12 bits are driven at once.

Top module: `adcb_host_port`

## Requirements
- R1: A request counts only while `en_i` is 1 and `sel_n_i` is 0 in the same cycle. Otherwise no conversion starts and `data_oe_o` stays 0.
- R2: With `rd_conv_i` = 0, a qualified request starts one conversion on the first clock edge at which it is seen, and a held request does not start another. With `rd_conv_i` = 1, a qualified request enables the data outputs.
- R3: When `half_i` = 0 at the start edge, a full conversion runs. Its result equals `sample_i` as it was at the start edge, and later changes of `sample_i` have no effect.
- R4: When `half_i` = 1 at the start edge, the conversion is cut short. Result bits 11..4 equal the latched sample bits 11..4, and result bits 3..0 are 0.
- R5: `busy_o` goes to 1 on the start edge and stays 1 for exactly 12 clock cycles for a full conversion, or exactly 8 for a short one. Otherwise it is 0.
- R6: A start request while `busy_o` = 1 is ignored. The running conversion keeps its length and its result.
- R7: During a read with `wide_i` = 1, `data_o` carries all 12 result bits, with bit 0 the LSB and bit 11 the MSB.
- R8: During a read with `wide_i` = 0 and `half_i` = 0, `data_o[11:4]` carries result bits 11..4 and `data_o[3:0]` is 0.
- R9: During a read with `wide_i` = 0 and `half_i` = 1, `data_o[3:0]` carries result bits 3..0 and `data_o[11:4]` is 0.
- R10: When no read is enabled, `data_oe_o` is 0 and `data_o` is high-impedance.
- R11: After reset, `busy_o` is 0 and the stored result reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable, active high |
| sel_n_i | input | 1 | Select, active low |
| rd_conv_i | input | 1 | 1 = read, 0 = start conversion |
| wide_i | input | 1 | 1 = drive all 12 bits on a read |
| half_i | input | 1 | Read: 0 = upper 8 bits, 1 = lower 4 bits; start: 1 = short 8-bit conversion |
| sample_i | input | 12 | Digital stand-in for the analog input |
| busy_o | output | 1 | 1 while a conversion runs |
| data_oe_o | output | 1 | 1 while `data_o` is driven |
| data_o | output | 12 | Tri-stated result bus |

## Verification
A wrong bit index or a wrong stop point in the approximation register shows up in two ways at the ports. `busy_o` falls one or more cycles early or late on that same conversion, and one of the three read formats returns a value other than the latched sample right after completion. A corrupted latch or a restart while busy shows as a changed result on the first read after `busy_o` falls. A decode error shows within the same cycle, through `data_oe_o` or a misplaced nibble on `data_o`.

// File: rtl/adcb_pkg.sv
package adcb_pkg;
  // read format picked by the decoder
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_FULL = 2'd1,
    RD_HIGH = 2'd2,
    RD_LOW  = 2'd3
  } rd_fmt_e;
endpackage

// File: rtl/adcb_decode.sv
module adcb_decode
  import adcb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en_i,
  input  logic    sel_n_i,
  input  logic    rd_conv_i,
  input  logic    wide_i,
  input  logic    half_i,
  input  logic    busy_i,
  output logic    start_o,
  output logic    short_o,
  output rd_fmt_e fmt_o
);
  logic qual, conv_req, conv_prev_q;

  assign qual     = en_i & ~sel_n_i;
  assign conv_req = qual & ~rd_conv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_prev_q <= 1'b0;
    else        conv_prev_q <= conv_req;
  end

  assign start_o = conv_req & ~conv_prev_q & ~busy_i;
  assign short_o = half_i;

  always_comb begin
    if (!(qual && rd_conv_i)) fmt_o = RD_NONE;
    else if (wide_i)          fmt_o = RD_FULL;
    else if (half_i)          fmt_o = RD_LOW;
    else                      fmt_o = RD_HIGH;
  end

  // R1
  start_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (en_i && !sel_n_i && !rd_conv_i));

  // R2
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
endmodule

// File: rtl/adcb_sar.sv
module adcb_sar #(
  parameter int DW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          short_i,
  input  logic [DW-1:0] sample_i,
  output logic          busy_o,
  output logic [DW-1:0] result_o,
  output logic          done_o
);
  localparam int IW = $clog2(DW);
  localparam int NW = DW - SW;
  localparam logic [IW-1:0] TOP_IDX   = IW'(DW - 1);
  localparam logic [IW-1:0] SHORT_END = IW'(NW);
  localparam logic [IW:0]   FULL_LEN  = (IW+1)'(DW);
  localparam logic [IW:0]   SHORT_LEN = (IW+1)'(SW);

  // one approximation step: keep the bit if the trial code does not exceed the sample
  function automatic logic keep_bit(input logic [DW-1:0] part,
                                    input logic [IW-1:0] idx,
                                    input logic [DW-1:0] samp);
    logic [DW-1:0] trial;
    trial = part | (DW'(1) << idx);
    return trial <= samp;
  endfunction

  logic          busy_q, short_q;
  logic [IW-1:0] idx_q, end_idx_q;
  logic [DW-1:0] samp_q, part_q, res_q, part_nxt;
  logic          last_step;
  logic [IW:0]   run_cnt_q;

  always_comb begin
    part_nxt = part_q;
    part_nxt[idx_q] = keep_bit(part_q, idx_q, samp_q);
  end

  assign last_step = busy_q && (idx_q == end_idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      short_q   <= 1'b0;
      idx_q     <= '0;
      end_idx_q <= '0;
      samp_q    <= '0;
      part_q    <= '0;
      res_q     <= '0;
    end else if (start_i && !busy_q) begin
      busy_q    <= 1'b1;
      short_q   <= short_i;
      idx_q     <= TOP_IDX;
      end_idx_q <= short_i ? SHORT_END : '0;
      samp_q    <= sample_i;
      part_q    <= '0;
    end else if (busy_q) begin
      part_q <= part_nxt;
      idx_q  <= idx_q - 1'b1;
      if (last_step) begin
        busy_q <= 1'b0;
        res_q  <= part_nxt;
      end
    end
  end

  // cycle counter kept for the length check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt_q <= '0;
    else if (busy_q) run_cnt_q <= run_cnt_q + 1'b1;
    else             run_cnt_q <= '0;
  end

  assign busy_o   = busy_q;
  assign result_o = res_q;
  assign done_o   = last_step;

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (run_cnt_q == (short_q ? SHORT_LEN : FULL_LEN)));

  // R3
  full_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !short_q) |-> (res_q == samp_q));

  // R4
  short_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && short_q) |->
      (res_q[DW-1:NW] == samp_q[DW-1:NW] && res_q[NW-1:0] == '0));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step) |=> ($stable(samp_q) && $stable(short_q) && busy_q));
endmodule

// File: rtl/adcb_outmux.sv
module adcb_outmux
  import adcb_pkg::*;
#(
  parameter int DW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rd_fmt_e       fmt_i,
  input  logic [DW-1:0] result_i,
  output logic          oe_o,
  output logic [DW-1:0] val_o
);
  localparam int NW = DW - SW;

  // place the result on the bus lines for a given read format
  function automatic logic [DW-1:0] place(input rd_fmt_e f, input logic [DW-1:0] r);
    logic [DW-1:0] v;
    v = '0;
    case (f)
      RD_FULL: v = r;
      RD_HIGH: v[DW-1:NW] = r[DW-1:NW];
      RD_LOW:  v[NW-1:0]  = r[NW-1:0];
      default: v = '0;
    endcase
    return v;
  endfunction

  assign oe_o  = (fmt_i != RD_NONE);
  assign val_o = place(fmt_i, result_i);

  // R9
  low_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i == RD_LOW) |-> (val_o[DW-1:NW] == '0));

  // R8
  high_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i == RD_HIGH) |-> (val_o[NW-1:0] == '0 && val_o[DW-1:NW] == result_i[DW-1:NW]));
endmodule

// File: rtl/adcb_host_port.sv
module adcb_host_port
  import adcb_pkg::*;
#(
  parameter int DW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          sel_n_i,
  input  logic          rd_conv_i,
  input  logic          wide_i,
  input  logic          half_i,
  input  logic [DW-1:0] sample_i,
  output logic          busy_o,
  output logic          data_oe_o,
  output logic [DW-1:0] data_o
);
  logic          start_w, short_w, busy_w, done_w, oe_w;
  rd_fmt_e       fmt_w;
  logic [DW-1:0] result_w, val_w;

  adcb_decode u_dec (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .sel_n_i(sel_n_i),
    .rd_conv_i(rd_conv_i), .wide_i(wide_i), .half_i(half_i),
    .busy_i(busy_w), .start_o(start_w), .short_o(short_w), .fmt_o(fmt_w)
  );

  adcb_sar #(.DW(DW), .SW(SW)) u_sar (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .short_i(short_w),
    .sample_i(sample_i), .busy_o(busy_w), .result_o(result_w), .done_o(done_w)
  );

  adcb_outmux #(.DW(DW), .SW(SW)) u_mux (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_w), .result_i(result_w),
    .oe_o(oe_w), .val_o(val_w)
  );

  assign busy_o    = busy_w;
  assign data_oe_o = oe_w;
  assign data_o    = oe_w ? val_w : {DW{1'bz}};

  // R10
  no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || sel_n_i || !rd_conv_i) |-> !data_oe_o);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && !busy_o) |=> busy_o);

  // R5
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> !busy_o);
endmodule

// File: tb/adcb_host_port_tb.sv
module adcb_host_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0, sel_n_i = 1'b1, rd_conv_i = 1'b1, wide_i = 1'b0, half_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic        busy_o, data_oe_o;
  wire  [11:0] data_o;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;

  adcb_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .sel_n_i(sel_n_i), .rd_conv_i(rd_conv_i),
    .wide_i(wide_i), .half_i(half_i), .sample_i(sample_i),
    .busy_o(busy_o), .data_oe_o(data_oe_o), .data_o(data_o)
  );

  always #10 clk = ~clk;

  function automatic logic [11:0] exp_res(input logic [11:0] s, input bit sh);
    return sh ? (s & 12'hFF0) : s;
  endfunction

  function automatic logic [11:0] exp_bus(input logic [11:0] r, input bit w, input bit h);
    if (w) return r;
    if (h) return {8'h00, r[3:0]};
    return {r[11:4], 4'h0};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic idle();
    en_i = 1'b0; sel_n_i = 1'b1; rd_conv_i = 1'b1; wide_i = 1'b0; half_i = 1'b0;
  endtask

  // start a conversion, optionally poke a second start while busy, count busy cycles
  task automatic convert(input logic [11:0] s, input bit sh, input bit poke, output int n);
    @(negedge clk);
    sample_i = s; en_i = 1'b1; sel_n_i = 1'b0; rd_conv_i = 1'b0; half_i = sh;
    @(negedge clk);
    idle();
    sample_i = ~s;
    n = 0;
    while (busy_o && n < 40) begin
      n++;
      if (poke && n == 3) begin
        en_i = 1'b1; sel_n_i = 1'b0; rd_conv_i = 1'b0; half_i = ~sh; sample_i = s ^ 12'h5A5;
      end else idle();
      @(negedge clk);
    end
    idle();
  endtask

  task automatic rd_chk(input bit w, input bit h, input logic [11:0] r, input string tag);
    @(negedge clk);
    en_i = 1'b1; sel_n_i = 1'b0; rd_conv_i = 1'b1; wide_i = w; half_i = h;
    #2;
    chk(data_oe_o === 1'b1, {tag, " oe"}, int'(data_oe_o), 1);
    chk(data_o === exp_bus(r, w, h), tag, int'(data_o), int'(exp_bus(r, w, h)));
    idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [11:0] s, r;
    bit sh;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busy_o == 1'b0, "R11 busy after reset", int'(busy_o), 0);
    chk(data_oe_o == 1'b0, "R10 idle oe", int'(data_oe_o), 0);
    rd_chk(1'b1, 1'b0, 12'h000, "R11 reset result");

    // R1 unqualified starts
    @(negedge clk); sample_i = 12'hABC; en_i = 1'b0; sel_n_i = 1'b0; rd_conv_i = 1'b0;
    @(negedge clk); idle(); @(negedge clk);
    chk(busy_o == 1'b0, "R1 start with en low", int'(busy_o), 0);
    en_i = 1'b1; sel_n_i = 1'b1; rd_conv_i = 1'b0;
    @(negedge clk); idle(); @(negedge clk);
    chk(busy_o == 1'b0, "R1 start with sel high", int'(busy_o), 0);
    // R1 unqualified read
    en_i = 1'b1; sel_n_i = 1'b1; rd_conv_i = 1'b1; wide_i = 1'b1; #2;
    chk(data_oe_o == 1'b0, "R1 read with sel high", int'(data_oe_o), 0);
    en_i = 1'b0; sel_n_i = 1'b0; #2;
    chk(data_oe_o == 1'b0, "R1 read with en low", int'(data_oe_o), 0);
    // R2 convert cycle type does not drive the bus
    en_i = 1'b1; rd_conv_i = 1'b0; #2;
    chk(data_oe_o == 1'b0, "R2 convert cycle no oe", int'(data_oe_o), 0);
    idle();

    // directed corners R3 R4 R5
    convert(12'hFFF, 1'b0, 1'b0, n);
    chk(n == 12, "R5 full busy length", n, 12);
    rd_chk(1'b1, 1'b0, 12'hFFF, "R3 full all ones");
    convert(12'h000, 1'b0, 1'b0, n);
    rd_chk(1'b1, 1'b0, 12'h000, "R3 full zero");
    convert(12'hFFF, 1'b1, 1'b0, n);
    chk(n == 8, "R5 short busy length", n, 8);
    rd_chk(1'b1, 1'b0, 12'hFF0, "R4 short low nibble zero");
    rd_chk(1'b0, 1'b1, 12'hFF0, "R9 short low read");

    // R2 held request starts only once
    @(negedge clk);
    sample_i = 12'h321; en_i = 1'b1; sel_n_i = 1'b0; rd_conv_i = 1'b0; half_i = 1'b1;
    repeat (20) @(negedge clk);
    chk(busy_o == 1'b0, "R2 held request single start", int'(busy_o), 0);
    idle();
    rd_chk(1'b1, 1'b0, 12'h320, "R2 held request result");

    // R6 start while busy ignored
    convert(12'h9C7, 1'b0, 1'b1, n);
    chk(n == 12, "R6 busy length with poke", n, 12);
    rd_chk(1'b1, 1'b0, 12'h9C7, "R6 result with poke");
    convert(12'h5E3, 1'b1, 1'b1, n);
    chk(n == 8, "R6 short length with poke", n, 8);
    rd_chk(1'b1, 1'b0, 12'h5E0, "R6 short result with poke");

    // random conversions and reads R3 R4 R7 R8 R9
    for (int i = 0; i < 40; i++) begin
      s  = 12'($urandom);
      sh = 1'($urandom);
      convert(s, sh, 1'b0, n);
      r = exp_res(s, sh);
      chk(n == (sh ? 8 : 12), sh ? "R5 random short length" : "R5 random full length", n, sh ? 8 : 12);
      rd_chk(1'b1, 1'b0, r, sh ? "R4 R7 random wide read" : "R3 R7 random wide read");
      rd_chk(1'b0, 1'b0, r, "R8 random upper read");
      rd_chk(1'b0, 1'b1, r, "R9 random lower read");
      @(negedge clk); #2;
      chk(data_oe_o == 1'b0, "R10 oe after read", int'(data_oe_o), 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule